// File: doc/BRIEF.md
# Parallel-Port Enhanced-Mode Write Cycle Controller with Watchdog

This block sits between a host write port and an enhanced-mode parallel port and runs one write cycle per accepted host request. An accepted request opens either an address cycle or a data cycle. The controller pulls the matching strobe low, holds the write line low, and drives the byte onto the port. It then waits for the peripheral to raise its handshake line.

The handshake line is asynchronous, so it passes through a synchroniser chain before its rising edge is detected. A watchdog counter starts on the clock edge that accepts the request. The cycle ends on the handshake or on watchdog expiry, whichever comes first. When the watchdog ends the cycle, a sticky timeout flag is set in bit 0 of the status word. No interrupt is raised. After each cycle, driver software reads the flag to decide whether to retry. It clears the flag by writing 1 to bit 0.

The host side uses valid/ready. A request is taken on a clock edge where `host_valid` and `host_ready` are both high. `host_ready` stays low for the whole port cycle, so the host is held off until the handshake or the timeout ends the cycle. The host must keep `host_is_addr` and `host_data` stable while `host_valid` is high and `host_ready` is low. The status and clear pins are plain control pins.

Top module: `pp_wr_watchdog`

## Requirements
- R1: After reset, `host_ready` is 1. `pp_addr_stb_n`, `pp_data_stb_n` and `pp_write_n` are 1, and `status_o` is 0.
- R2: A request is accepted on a clock edge where `host_valid` and `host_ready` are both 1. From the next cycle until the cycle ends, `pp_write_n` is 0 and `pp_data_o` equals the accepted byte. `host_is_addr`=1 selects an address cycle, in which only `pp_addr_stb_n` is 0. `host_is_addr`=0 selects a data cycle, in which only `pp_data_stb_n` is 0.
- R3: `host_ready` is 0 from the cycle after acceptance until the cycle ends. `host_valid`, `host_is_addr` and `host_data` have no effect while it is 0.
- R4: A rising edge of `pp_hs_n` ends the cycle. The edge passes through a 2-flop synchroniser and an edge detector. If `pp_hs_n` rises before clock edge E, the strobe and `pp_write_n` return to 1, and `host_ready` to 1, on edge E+2.
- R5: The watchdog limit is WD_CYCLES = CLK_MHZ*WD_US clock cycles. If no handshake edge ends the cycle, the strobe stays asserted for exactly WD_CYCLES cycles and then releases.
- R6: If the handshake and watchdog expiry end the cycle on the same edge, the handshake wins and the timeout flag is not set by that cycle.
- R7: A watchdog-ended cycle sets `status_o[0]` on the same edge that releases the strobe. Bits 7:1 of `status_o` always read 0.
- R8: The timeout flag is sticky. It keeps its value through later cycles, including cycles that end on a handshake. It is cleared only by an edge with `csr_we`=1 and `csr_wdata[0]`=1. A write with `csr_wdata[0]`=0 leaves it unchanged.
- R9: If a timeout and a clear fall on the same edge, the flag ends up set.
- R10: A new request is accepted while the timeout flag is set, and it runs a normal cycle.
- R11: Only a rising edge of `pp_hs_n` inside an active cycle ends it. A level already high at acceptance, or an edge while idle, does not shorten the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host write request present |
| host_ready | output | 1 | Controller can accept a request; low for the whole port cycle |
| host_is_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| host_data | input | DATA_W | Byte to write |
| pp_data_o | output | DATA_W | Byte driven onto the port |
| pp_addr_stb_n | output | 1 | Address strobe, active low |
| pp_data_stb_n | output | 1 | Data strobe, active low |
| pp_write_n | output | 1 | Write direction, low during a cycle |
| pp_hs_n | input | 1 | Peripheral handshake (asynchronous); its rising edge ends a cycle |
| csr_we | input | 1 | Status write enable |
| csr_wdata | input | CSR_W | Status write data; bit 0 = 1 clears the timeout flag |
| status_o | output | CSR_W | Status word; bit 0 is the timeout flag |

## Verification
The bench builds the block with CLK_MHZ=200 and WD_US=1, which gives a 200-cycle watchdog instead of 2000. Many expiries fit in a short run at this value. Handshake delays can be placed on every side of the limit, including the pair where the synchronised edge lands on the expiry edge (handshake wins) and one cycle after it (timeout wins). The shorter window also lets a status clear be timed to coincide with an expiry.

// File: rtl/pp_wd_pkg.sv
package pp_wd_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;

  typedef enum logic {
    CYC_DATA = 1'b0,
    CYC_ADDR = 1'b1
  } cyc_kind_t;

  // Watchdog length in clock cycles for a clock in MHz and a window in us.
  function automatic int wd_cycles(input int clk_mhz, input int win_us);
    return clk_mhz * win_us;
  endfunction

endpackage

// File: rtl/pp_hs_sync.sv
module pp_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

  // A detected edge is a single-cycle pulse.
  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pp_wd_timer.sv
module pp_wd_timer #(
  parameter int TERM = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = (TERM > 1) ? $clog2(TERM) : 1;
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !expire_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pp_wr_seq.sv
module pp_wr_seq
  import pp_wd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_is_addr,
  input  logic [DATA_W-1:0] host_data,
  output logic              host_ready,
  input  logic              hs_rise,
  input  logic              wd_expire,
  output logic              busy_o,
  output logic              timeout_evt_o,
  output logic [DATA_W-1:0] pp_data_o,
  output logic              pp_addr_stb_n,
  output logic              pp_data_stb_n,
  output logic              pp_write_n
);

  seq_state_t        state_q;
  cyc_kind_t         kind_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              end_now;

  assign accept  = (state_q == SEQ_IDLE) && host_valid;
  assign end_now = (state_q == SEQ_BUSY) && (hs_rise || wd_expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      kind_q  <= CYC_DATA;
      data_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (accept) begin
          state_q <= SEQ_BUSY;
          kind_q  <= host_is_addr ? CYC_ADDR : CYC_DATA;
          data_q  <= host_data;
        end
        SEQ_BUSY: if (end_now) state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q == SEQ_BUSY);
  assign host_ready    = (state_q == SEQ_IDLE);
  assign timeout_evt_o = busy_o && wd_expire && !hs_rise;
  assign pp_data_o     = data_q;
  assign pp_addr_stb_n = !(busy_o && kind_q == CYC_ADDR);
  assign pp_data_stb_n = !(busy_o && kind_q == CYC_DATA);
  assign pp_write_n    = !busy_o;

  assert_accept_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready) |=> (!pp_addr_stb_n || !pp_data_stb_n));

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !end_now) |=> $stable(pp_data_o));

  assert_ready_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !end_now) |=> !host_ready);

  assert_hs_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && hs_rise) |=> (host_ready && pp_write_n));

endmodule

// File: rtl/pp_tout_flag.sv
module pp_tout_flag #(
  parameter int CSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] status_o
);

  logic flag_q;
  logic clr_req;

  assign clr_req = csr_we && csr_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign status_o = {{(CSR_W-1){1'b0}}, flag_q};

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> status_o[0]);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !clr_req) |=> status_o[0]);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_i) |=> !status_o[0]);

endmodule

// File: rtl/pp_wr_watchdog.sv
module pp_wr_watchdog
  import pp_wd_pkg::*;
#(
  parameter int CLK_MHZ     = 200,
  parameter int WD_US       = 10,
  parameter int DATA_W      = 8,
  parameter int CSR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_is_addr,
  input  logic [DATA_W-1:0] host_data,
  output logic [DATA_W-1:0] pp_data_o,
  output logic              pp_addr_stb_n,
  output logic              pp_data_stb_n,
  output logic              pp_write_n,
  input  logic              pp_hs_n,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  status_o
);

  localparam int WD_CYCLES = wd_cycles(CLK_MHZ, WD_US);

  logic hs_level;
  logic hs_rise;
  logic busy;
  logic wd_expire;
  logic timeout_evt;

  pp_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pp_hs_n),
    .level_o (hs_level),
    .rise_o  (hs_rise)
  );

  pp_wd_timer #(.TERM(WD_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (busy),
    .expire_o (wd_expire)
  );

  pp_wr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_valid    (host_valid),
    .host_is_addr  (host_is_addr),
    .host_data     (host_data),
    .host_ready    (host_ready),
    .hs_rise       (hs_rise),
    .wd_expire     (wd_expire),
    .busy_o        (busy),
    .timeout_evt_o (timeout_evt),
    .pp_data_o     (pp_data_o),
    .pp_addr_stb_n (pp_addr_stb_n),
    .pp_data_stb_n (pp_data_stb_n),
    .pp_write_n    (pp_write_n)
  );

  pp_tout_flag #(.CSR_W(CSR_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (timeout_evt),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .status_o  (status_o)
  );

  // Handshake edge at the expiry point wins: no flag from that cycle.
  assert_hs_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hs_rise && !status_o[0] && !csr_we) |=> !status_o[0]);

  // A cycle that is still running never outlives the watchdog: expiry releases it.
  assert_expire_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wd_expire) |=> host_ready);

  // hs_level is used only through its edge; an idle level must not start anything.
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && !host_valid && hs_level) |=> host_ready);

endmodule

// File: tb/pp_wr_watchdog_bench.sv
`timescale 1ns/1ps
module pp_wr_watchdog_bench;

  localparam int CLK_MHZ = 200;
  localparam int WD_US   = 1;
  localparam int T       = CLK_MHZ * WD_US;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0;
  logic       host_ready;
  logic       host_is_addr = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic [7:0] pp_data_o;
  logic       pp_addr_stb_n;
  logic       pp_data_stb_n;
  logic       pp_write_n;
  logic       pp_hs_n = 1'b0;
  logic       csr_we = 1'b0;
  logic [7:0] csr_wdata = 8'h00;
  logic [7:0] status_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  exp_flag = 1'b0;
  bit  done     = 1'b0;
  int  seed_dummy;

  always #2.5 clk = ~clk;

  pp_wr_watchdog #(.CLK_MHZ(CLK_MHZ), .WD_US(WD_US)) u_pp_wr_watchdog (
    .clk (clk), .rst_n (rst_n),
    .host_valid (host_valid), .host_ready (host_ready),
    .host_is_addr (host_is_addr), .host_data (host_data),
    .pp_data_o (pp_data_o), .pp_addr_stb_n (pp_addr_stb_n),
    .pp_data_stb_n (pp_data_stb_n), .pp_write_n (pp_write_n),
    .pp_hs_n (pp_hs_n), .csr_we (csr_we), .csr_wdata (csr_wdata),
    .status_o (status_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Handshake raised at negedge index k ends the cycle after k+3 strobe samples.
  function automatic bit hs_wins(input int k);
    return (k >= 0) && (k + 3 <= T);
  endfunction

  function automatic int exp_lows(input int k);
    return hs_wins(k) ? k + 3 : T;
  endfunction

  // One write cycle. k: negedge index to raise the handshake (-1 never).
  // clr_at: index at which a status clear is driven for one edge (-1 never).
  task automatic run_cycle(input bit is_addr, input logic [7:0] d, input int k,
                           input int clr_at, input bit poke_busy, input string req);
    int  lows = 0;
    int  idx  = 0;
    int  bad  = 0;
    @(negedge clk);
    chk(host_ready == 1'b1, "R10 ready before request", host_ready, 1);
    host_valid = 1'b1; host_is_addr = is_addr; host_data = d;
    @(negedge clk);
    host_valid = 1'b0;
    while (!pp_write_n && idx < T + 10) begin
      if (idx == clr_at + 1) csr_we = 1'b0;
      if (is_addr ? (pp_addr_stb_n || !pp_data_stb_n)
                  : (pp_data_stb_n || !pp_addr_stb_n)) bad++;
      if (pp_data_o != d || host_ready) bad++;
      if (poke_busy && idx == 1) begin
        host_valid = 1'b1; host_is_addr = ~is_addr; host_data = ~d;
      end
      if (poke_busy && idx == 2) host_valid = 1'b0;
      if (idx == k) pp_hs_n = 1'b1;
      if (idx == clr_at) begin csr_we = 1'b1; csr_wdata = 8'h01; end
      lows++; idx++;
      @(negedge clk);
    end
    csr_we = 1'b0; host_valid = 1'b0;
    chk(bad == 0, "R2/R3 strobe, write, data and ready during cycle", bad, 0);
    chk(lows == exp_lows(k), {req, " cycle length"}, lows, exp_lows(k));
    chk(host_ready && pp_addr_stb_n && pp_data_stb_n && pp_write_n,
        "R4/R5 released after end", host_ready, 1);
    if (!hs_wins(k)) exp_flag = 1'b1;
    if (clr_at >= 0 && clr_at + 1 < exp_lows(k)) exp_flag = hs_wins(k) ? 1'b0 : 1'b1;
    chk(status_o == {7'b0, exp_flag}, {req, " R7 status after cycle"}, status_o, exp_flag);
    pp_hs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csr_write(input logic [7:0] v, input string req);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
    if (v[0]) exp_flag = 1'b0;
    chk(status_o == {7'b0, exp_flag}, req, status_o, exp_flag);
  endtask

  initial begin
    seed_dummy = $urandom(32'd51873);
    repeat (3) @(negedge clk);
    chk(host_ready == 1'b1, "R1 ready in reset", host_ready, 1);
    chk(pp_addr_stb_n && pp_data_stb_n && pp_write_n, "R1 strobes idle in reset",
        {pp_addr_stb_n, pp_data_stb_n, pp_write_n}, 7);
    chk(status_o == 8'h00, "R1 status in reset", status_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(host_ready && pp_write_n && status_o == 0, "R1 idle after reset", status_o, 0);

    // Directed corners.
    run_cycle(1'b1, 8'hA5, 0, -1, 1'b1, "R2 R3 R4 address fast hs");
    run_cycle(1'b0, 8'h3C, 7, -1, 1'b0, "R2 R4 data hs");
    run_cycle(1'b0, 8'h11, T - 3, -1, 1'b0, "R6 hs on expiry edge");
    run_cycle(1'b1, 8'h22, T - 2, -1, 1'b0, "R5 hs one late");
    run_cycle(1'b0, 8'h5A, 4, -1, 1'b0, "R8 R10 sticky through hs cycle");
    csr_write(8'hFE, "R8 write bit0=0 keeps flag");
    csr_write(8'h01, "R8 clear with bit0=1");
    run_cycle(1'b1, 8'h77, -1, T - 1, 1'b0, "R9 clear on expiry edge");
    csr_write(8'h01, "R8 clear again");
    // Handshake already high before the request: no edge, so timeout.
    pp_hs_n = 1'b1;
    repeat (5) @(negedge clk);
    run_cycle(1'b0, 8'h99, -1, -1, 1'b0, "R11 level high at start");
    csr_write(8'h01, "R8 clear after R11");
    // Edge while idle, then a fast-handshake cycle must still see its own edge.
    pp_hs_n = 1'b1; repeat (3) @(negedge clk); pp_hs_n = 1'b0; repeat (4) @(negedge clk);
    run_cycle(1'b1, 8'h0F, 10, -1, 1'b0, "R11 idle edge ignored");

    // Random cycles.
    for (int i = 0; i < 40; i++) begin
      int  kr;
      bit  ia;
      logic [7:0] dr;
      kr = ($urandom_range(0, 7) == 0) ? -1 : int'($urandom_range(0, T + 4));
      ia = 1'($urandom_range(0, 1));
      dr = 8'($urandom_range(0, 255));
      run_cycle(ia, dr, kr, -1, 1'($urandom_range(0, 1)), "R2 R4 R5 random");
      if ($urandom_range(0, 2) == 0) csr_write(8'h01, "R8 random clear");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule